// File: doc/BRIEF.md
# Card Host Error Recovery Sequencer

This block runs the recovery procedure of a memory-card host controller on its own once an error interrupt has been taken. A single `start_i` pulse begins a sequence. The block masks the error interrupt signal and resets the command line, the data line, or both, depending on which error groups are flagged. It then snapshots the error status and clears it with a write-one-to-clear mask. Finally it requests an abort command and waits for the controller to become idle.

After the abort the block classifies the failure from three sources: the post-abort status, the data-timeout flag, and a sample of the four DAT line levels. The DAT sample is taken only after a settling wait of more than 40 µs. A one-cycle `done_o` pulse marks the end of the sequence. It comes with the result (recoverable or not), the saved status, and a sticky flag that shows a poll loop ran out of time.

The controller's command and data engines sit outside this block. Each soft reset and the abort are modelled as a request pulse out and a busy or inhibit level back in.

Top module: `err_recov_seq`

## Requirements
- R1: `err_int_en_o` is 0 from the cycle after an accepted start until the sequence ends, and is 1 in the `done_o` cycle and whenever the block is idle.
- R2: A `cmd_rst_o` pulse of one cycle is issued only if any of status bits 3..0 is 1. The sequence then waits for `cmd_rst_busy_i` to read 0.
- R3: A `dat_rst_o` pulse of one cycle is issued only if any of status bits 4..6 is 1. It never comes before the command-line reset of the same sequence, and the sequence waits for `dat_rst_busy_i` to read 0.
- R4: After the resets, the whole `err_sts_i` word is captured into `saved_sts_o`. On the next cycle `err_clr_o` carries ones in exactly the captured bit positions for one cycle, and is zero at all other times. Bits above 6 are saved and cleared but trigger no reset.
- R5: One `abort_req_o` pulse follows the clear. Classification starts only once `cmd_inhibit_i` and `dat_inhibit_i` are both 0.
- R6: If any post-abort status bit 3..0 is 1, or bit 4 (data timeout) is 1, the result is non-recoverable and no settling wait is taken.
- R7: Otherwise the block waits at least ceil(CLK_KHZ*WAIT_US/1000)+1 cycles and then samples `dat_level_i`. All four lines high gives recoverable (`recoverable_o`=1); any line low gives non-recoverable.
- R8: If any poll loop exceeds WDOG_CYC cycles, the sequence ends non-recoverable with `timeout_o`=1. `timeout_o` stays 1 until the next accepted start.
- R9: `done_o` is a single-cycle pulse with valid `recoverable_o` and `timeout_o`. A start seen while a sequence runs is ignored and produces no second sequence.
- R10: During reset, `err_int_en_o`=1 and `done_o`, `busy_o`, `timeout_o`, `recoverable_o`, `saved_sts_o` and `err_clr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| err_sts_i | input | ERR_W | Live error status word |
| cmd_rst_busy_i | input | 1 | Command-line soft reset still in progress |
| dat_rst_busy_i | input | 1 | Data-line soft reset still in progress |
| cmd_inhibit_i | input | 1 | Command line busy |
| dat_inhibit_i | input | 1 | Data line busy |
| dat_level_i | input | 4 | DAT line levels |
| cmd_rst_o | output | 1 | Command-line soft reset request pulse |
| dat_rst_o | output | 1 | Data-line soft reset request pulse |
| err_clr_o | output | ERR_W | Write-one-to-clear mask pulse |
| abort_req_o | output | 1 | Abort command request pulse |
| err_int_en_o | output | 1 | Error interrupt signal enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | End-of-sequence pulse |
| recoverable_o | output | 1 | Result: 1 recoverable, 0 non-recoverable |
| timeout_o | output | 1 | Sticky poll-watchdog expiry flag |
| saved_sts_o | output | ERR_W | Status captured before the clear |

## Verification
A wrong state in the sequencer shows at the ports within one sequence. It can appear as a reset pulse for a group whose bits are all zero, or as a data reset that comes before the command reset. It can also appear as a leftover status bit after the clear, because the mask did not match the snapshot. A settle counter loaded with the wrong value is exposed by a sequence that finishes in fewer cycles than the required wait. It is also exposed by a DAT level that rises part-way through the wait and yields the wrong result. A stuck poll is caught by the watchdog within a few hundred cycles, and the same path checks that the timeout flag stays sticky afterwards.

// File: rtl/erq_pkg.sv
package erq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD_CHK, S_CMD_RST, S_CMD_WAIT,
    S_DAT_CHK, S_DAT_RST, S_DAT_WAIT, S_SAVE,
    S_CLEAR, S_ABORT, S_ABT_WAIT, S_EVAL,
    S_SETTLE, S_DONE
  } erq_state_e;

  // cycles for a wait of wait_us at clk_khz, rounded up, plus one of margin
  function automatic int unsigned erq_settle_cycles(input int unsigned clk_khz,
                                                    input int unsigned wait_us);
    return (clk_khz * wait_us + 999) / 1000 + 1;
  endfunction

endpackage

// File: rtl/erq_downcnt.sv
module erq_downcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  assign cnt_en = load_i | dec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/erq_status_cap.sv
module erq_status_cap #(
  parameter int unsigned ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             clr_i,
  input  logic [ERR_W-1:0] sts_i,
  output logic [ERR_W-1:0] saved_o,
  output logic [ERR_W-1:0] clr_mask_o
);

  logic [ERR_W-1:0] saved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_q <= '0;
    end else if (cap_i) begin
      saved_q <= sts_i;
    end
  end

  assign saved_o    = saved_q;
  assign clr_mask_o = {ERR_W{clr_i}} & saved_q;

endmodule

// File: rtl/err_recov_seq.sv
module err_recov_seq
  import erq_pkg::*;
#(
  parameter int unsigned ERR_W    = 16,
  parameter int unsigned CLK_KHZ  = 250000,
  parameter int unsigned WAIT_US  = 40,
  parameter int unsigned WDOG_CYC = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ERR_W-1:0] err_sts_i,
  input  logic             cmd_rst_busy_i,
  input  logic             dat_rst_busy_i,
  input  logic             cmd_inhibit_i,
  input  logic             dat_inhibit_i,
  input  logic [3:0]       dat_level_i,
  output logic             cmd_rst_o,
  output logic             dat_rst_o,
  output logic [ERR_W-1:0] err_clr_o,
  output logic             abort_req_o,
  output logic             err_int_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             recoverable_o,
  output logic             timeout_o,
  output logic [ERR_W-1:0] saved_sts_o
);

  localparam int unsigned SETTLE_CYC = erq_settle_cycles(CLK_KHZ, WAIT_US);
  localparam int unsigned SET_W      = $clog2(SETTLE_CYC + 1);
  localparam int unsigned WD_W       = $clog2(WDOG_CYC + 1);
  localparam int unsigned CMD_LO     = 0;
  localparam int unsigned CMD_HI     = 3;
  localparam int unsigned DAT_LO     = 4;
  localparam int unsigned DAT_HI     = 6;
  localparam int unsigned DTO_BIT    = 4;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  erq_state_e st_q, st_d;
  logic go_done, fin_recov, fin_to, accept;
  logic wd_load, wd_dec, wd_zero;
  logic set_load, set_dec, set_zero;
  logic recov_q, to_q;
  logic cmd_grp, dat_grp, post_fail;

  assign cmd_grp   = |err_sts_i[CMD_HI:CMD_LO];
  assign dat_grp   = |err_sts_i[DAT_HI:DAT_LO];
  assign post_fail = cmd_grp | err_sts_i[DTO_BIT];
  assign accept    = (st_q == S_IDLE) && start_i;

  always_comb begin
    st_d      = st_q;
    go_done   = 1'b0;
    fin_recov = 1'b0;
    fin_to    = 1'b0;
    wd_load   = 1'b0;
    wd_dec    = 1'b0;
    set_load  = 1'b0;
    set_dec   = 1'b0;
    unique case (st_q)
      S_IDLE:    if (start_i) st_d = S_CMD_CHK;
      S_CMD_CHK: st_d = cmd_grp ? S_CMD_RST : S_DAT_CHK;
      S_CMD_RST: begin
        wd_load = 1'b1;
        st_d    = S_CMD_WAIT;
      end
      S_CMD_WAIT: begin
        if (!cmd_rst_busy_i) begin
          st_d = S_DAT_CHK;
        end else if (wd_zero) begin
          go_done = 1'b1;
          fin_to  = 1'b1;
          st_d    = S_DONE;
        end else begin
          wd_dec = 1'b1;
        end
      end
      S_DAT_CHK: st_d = dat_grp ? S_DAT_RST : S_SAVE;
      S_DAT_RST: begin
        wd_load = 1'b1;
        st_d    = S_DAT_WAIT;
      end
      S_DAT_WAIT: begin
        if (!dat_rst_busy_i) begin
          st_d = S_SAVE;
        end else if (wd_zero) begin
          go_done = 1'b1;
          fin_to  = 1'b1;
          st_d    = S_DONE;
        end else begin
          wd_dec = 1'b1;
        end
      end
      S_SAVE:  st_d = S_CLEAR;
      S_CLEAR: st_d = S_ABORT;
      S_ABORT: begin
        wd_load = 1'b1;
        st_d    = S_ABT_WAIT;
      end
      S_ABT_WAIT: begin
        if (!cmd_inhibit_i && !dat_inhibit_i) begin
          st_d = S_EVAL;
        end else if (wd_zero) begin
          go_done = 1'b1;
          fin_to  = 1'b1;
          st_d    = S_DONE;
        end else begin
          wd_dec = 1'b1;
        end
      end
      S_EVAL: begin
        if (post_fail) begin
          go_done = 1'b1;
          st_d    = S_DONE;
        end else begin
          set_load = 1'b1;
          st_d     = S_SETTLE;
        end
      end
      S_SETTLE: begin
        if (set_zero) begin
          go_done   = 1'b1;
          fin_recov = &dat_level_i;
          st_d      = S_DONE;
        end else begin
          set_dec = 1'b1;
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      recov_q <= 1'b0;
      to_q    <= 1'b0;
    end else if (accept) begin
      recov_q <= 1'b0;
      to_q    <= 1'b0;
    end else if (go_done) begin
      recov_q <= fin_recov;
      to_q    <= fin_to;
    end
  end

  erq_downcnt #(.W(WD_W)) wdog_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_i    (wd_load),
    .load_val_i(WD_W'(WDOG_CYC)),
    .dec_i     (wd_dec),
    .zero_o    (wd_zero)
  );

  erq_downcnt #(.W(SET_W)) settle_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_i    (set_load),
    .load_val_i(SET_W'(SETTLE_CYC)),
    .dec_i     (set_dec),
    .zero_o    (set_zero)
  );

  erq_status_cap #(.ERR_W(ERR_W)) cap_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cap_i     (st_q == S_SAVE),
    .clr_i     (st_q == S_CLEAR),
    .sts_i     (err_sts_i),
    .saved_o   (saved_sts_o),
    .clr_mask_o(err_clr_o)
  );

  assign cmd_rst_o     = (st_q == S_CMD_RST);
  assign dat_rst_o     = (st_q == S_DAT_RST);
  assign abort_req_o   = (st_q == S_ABORT);
  assign done_o        = (st_q == S_DONE);
  assign busy_o        = (st_q != S_IDLE) && (st_q != S_DONE);
  assign err_int_en_o  = !busy_o;
  assign recoverable_o = recov_q;
  assign timeout_o     = to_q;

endmodule

// File: rtl/erq_chk.sv
module erq_chk #(
  parameter int unsigned ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             cmd_rst_o,
  input logic             dat_rst_o,
  input logic [ERR_W-1:0] err_clr_o,
  input logic             abort_req_o,
  input logic             err_int_en_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             recoverable_o,
  input logic             timeout_o
);

  // R1
  en_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !err_int_en_o);

  // R1
  done_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> err_int_en_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R8
  timeout_nonrec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && timeout_o) |-> !recoverable_o);

  // R5
  abort_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_rst_o, dat_rst_o, abort_req_o, |err_clr_o}));

endmodule

bind err_recov_seq erq_chk #(.ERR_W(ERR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .cmd_rst_o    (cmd_rst_o),
  .dat_rst_o    (dat_rst_o),
  .err_clr_o    (err_clr_o),
  .abort_req_o  (abort_req_o),
  .err_int_en_o (err_int_en_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .recoverable_o(recoverable_o),
  .timeout_o    (timeout_o)
);

// File: tb/err_recov_seq_tb_top.sv
module err_recov_seq_tb_top;

  localparam int ERR_W    = 16;
  localparam int SETTLE   = (250000 * 40 + 999) / 1000 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             start_i = 1'b0;
  logic [ERR_W-1:0] err_sts;
  logic             cmd_busy, dat_busy, inh;
  logic [3:0]       ccnt, dcnt, icnt;
  logic [3:0]       dat_lvl = 4'hF;
  logic             cmd_rst_o, dat_rst_o, abort_req_o, err_int_en_o;
  logic             busy_o, done_o, recoverable_o, timeout_o;
  logic [ERR_W-1:0] err_clr_o, saved_sts_o;

  logic             ld = 1'b0;
  logic [ERR_W-1:0] ld_val = '0;
  logic [ERR_W-1:0] aerr = '0;
  logic             hang_cmd = 1'b0, hang_abt = 1'b0;

  int n_tests = 0, n_fail = 0, cyc = 0, start_cyc = 0;
  int n_push = 0, n_done = 0;

  err_recov_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .err_sts_i(err_sts),
    .cmd_rst_busy_i(cmd_busy), .dat_rst_busy_i(dat_busy),
    .cmd_inhibit_i(inh && (icnt > 4'd3)), .dat_inhibit_i(inh),
    .dat_level_i(dat_lvl), .cmd_rst_o(cmd_rst_o), .dat_rst_o(dat_rst_o),
    .err_clr_o(err_clr_o), .abort_req_o(abort_req_o), .err_int_en_o(err_int_en_o),
    .busy_o(busy_o), .done_o(done_o), .recoverable_o(recoverable_o),
    .timeout_o(timeout_o), .saved_sts_o(saved_sts_o)
  );

  // controller model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_sts <= '0; cmd_busy <= 1'b0; dat_busy <= 1'b0; inh <= 1'b0;
      ccnt <= '0; dcnt <= '0; icnt <= '0;
    end else begin
      if (ld) err_sts <= ld_val;
      else if (abort_req_o) err_sts <= (err_sts & ~err_clr_o) | aerr;
      else err_sts <= err_sts & ~err_clr_o;
      if (cmd_rst_o) begin cmd_busy <= 1'b1; ccnt <= 4'd5; end
      else if (cmd_busy && !hang_cmd) begin
        if (ccnt == 0) cmd_busy <= 1'b0; else ccnt <= ccnt - 4'd1;
      end
      if (dat_rst_o) begin dat_busy <= 1'b1; dcnt <= 4'd6; end
      else if (dat_busy) begin
        if (dcnt == 0) dat_busy <= 1'b0; else dcnt <= dcnt - 4'd1;
      end
      if (abort_req_o) begin inh <= 1'b1; icnt <= 4'd9; end
      else if (inh && !hang_abt) begin
        if (icnt == 0) inh <= 1'b0; else icnt <= icnt - 4'd1;
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic recov; logic to; logic [ERR_W-1:0] saved; logic [ERR_W-1:0] fin;
    int ncmd; int ndat; int min_lat;
  } exp_t;
  exp_t q[$];

  // monitor
  int mcmd = 0, mdat = 0, tcmd = 0, tdat = 0;
  logic en_bad = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_rst_o) begin mcmd++; tcmd = cyc; end
      if (dat_rst_o) begin mdat++; tdat = cyc; end
      if (busy_o && err_int_en_o) en_bad = 1'b1;
      if (done_o) begin
        exp_t e;
        n_done++;
        if (q.size() == 0) chk(1'b0, "R9 unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk(recoverable_o == e.recov, "R6/R7 result", recoverable_o, e.recov);
          chk(timeout_o == e.to, "R8 timeout", timeout_o, e.to);
          chk(mcmd == e.ncmd, "R2 cmd resets", mcmd, e.ncmd);
          chk(mdat == e.ndat, "R3 dat resets", mdat, e.ndat);
          chk(!en_bad && err_int_en_o, "R1 enable", en_bad, 0);
          if (mcmd == 1 && mdat == 1) chk(tcmd < tdat, "R3 order", tdat, tcmd);
          if (!e.to) begin
            chk(saved_sts_o == e.saved, "R4 saved", saved_sts_o, e.saved);
            chk(err_sts == e.fin, "R4 clear mask", err_sts, e.fin);
            chk(cyc - start_cyc >= e.min_lat, "R7 settle time", cyc - start_cyc, e.min_lat);
          end
        end
        mcmd = 0; mdat = 0; en_bad = 1'b0;
      end
    end
  end

  // driver
  task automatic run(input logic [ERR_W-1:0] sts, input logic [ERR_W-1:0] ae,
                     input logic [3:0] lvl, input logic hc, input logic ha,
                     input logic late, input logic dbl);
    exp_t e;
    logic settle;
    e.ncmd  = (|sts[3:0]) ? 1 : 0;
    e.ndat  = (hc && e.ncmd == 1) ? 0 : ((|sts[6:4]) ? 1 : 0);
    e.to    = (hc && e.ncmd == 1) || ha;
    settle  = !e.to && !(|ae[3:0]) && !ae[4];
    e.recov = settle && (late ? 1'b1 : (&lvl));
    e.saved = sts;
    e.fin   = ae;
    e.min_lat = settle ? SETTLE : 0;
    q.push_back(e); n_push++;
    @(negedge clk);
    ld = 1'b1; ld_val = sts; aerr = ae; hang_cmd = hc; hang_abt = ha;
    dat_lvl = late ? 4'h0 : lvl;
    @(negedge clk);
    ld = 1'b0; start_i = 1'b1; start_cyc = cyc;
    @(negedge clk);
    start_i = 1'b0;
    chk(!err_int_en_o, "R1 enable drops", err_int_en_o, 0);
    if (dbl) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    if (late) begin
      repeat (3000) @(negedge clk);
      dat_lvl = 4'hF;
    end
    while (!done_o) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(!busy_o && err_int_en_o, "R9 no second run", busy_o, 0);
    if (e.to) chk(timeout_o, "R8 sticky", timeout_o, 1);
    hang_cmd = 1'b0; hang_abt = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk(err_int_en_o && !done_o && !busy_o && !timeout_o && !recoverable_o &&
        saved_sts_o == 0 && err_clr_o == 0, "R10 reset state", busy_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run(16'h0000, 16'h0000, 4'hF, 0, 0, 0, 0); // R7 clean, recoverable
    run(16'h0003, 16'h0000, 4'hF, 0, 0, 0, 1); // R2 cmd reset, R9 extra start
    run(16'h0050, 16'h0000, 4'hF, 0, 0, 0, 0); // R3 dat reset only
    run(16'h0022, 16'h0000, 4'hF, 0, 0, 0, 0); // R2 R3 both, order
    run(16'h0200, 16'h0000, 4'hF, 0, 0, 0, 0); // R4 high bit saved, no reset
    run(16'h0000, 16'h0004, 4'hF, 0, 0, 0, 0); // R6 post-abort cmd error
    run(16'h0000, 16'h0010, 4'hF, 0, 0, 0, 0); // R6 data timeout bit
    run(16'h0000, 16'h0000, 4'hE, 0, 0, 0, 0); // R7 one DAT line low
    run(16'h0000, 16'h0000, 4'hF, 0, 0, 1, 0); // R7 lines rise during wait
    run(16'h0001, 16'h0000, 4'hF, 1, 0, 0, 0); // R8 cmd reset hangs
    run(16'h0000, 16'h0000, 4'hF, 0, 0, 0, 0); // R8 flag cleared by next start
    run(16'h0000, 16'h0000, 4'hF, 0, 1, 0, 0); // R8 abort inhibit hangs
    chk(q.size() == 0 && n_done == n_push, "R9 done count", n_done, n_push);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule